// File: doc/BRIEF.md
# Clear-on-read interrupt status unit

This block gathers up to 32 interrupt events into one interrupt line for a processor. It sits on a simple 32-bit memory-mapped register bus. Every event input is a single-cycle pulse. The pulse sets a sticky pending bit, and that bit holds until software collects it. A read/write mask register chooses which pending bits may drive the interrupt line. Events are still recorded while they are masked.

Software services the interrupt by reading the acknowledge register. The read returns the pending set and clears the bits it returned. A debugger can inspect the same register without disturbing it. The access qualifier carries the lowest bit of the requesting master's ID, and when that bit is 1 the read has no side effect.

Two acknowledge reads must not follow each other directly. The block detects such a read, rejects it and flags it on a dedicated output.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous active-low reset, all pending bits and all mask bits are 0 and `irq_out` is low.
- R2: A 1 on `event_pulse[i]` sets pending bit i at the next clock edge, whether or not mask bit i is set. The bit stays set until it is cleared by an acknowledge read.
- R3: A read at offset 0x10 (acknowledge) returns the pending bits in the same cycle, with bit i standing for event i. At the end of that cycle the returned bits are cleared, provided the access is not from a debugger.
- R4: If an event pulse arrives in the same cycle as a clearing acknowledge read, its pending bit is set after the edge. The event is not lost.
- R5: When `bus_master_lsb` is 1 (debugger access), an acknowledge read returns the pending bits but clears none of them.
- R6: The mask register at offset 0x14 is written by a bus write and read back unchanged. Mask bit i gates pending bit i.
- R7: `irq_out` is high exactly while the AND of the pending and mask bits is non-zero. Setting a mask bit over an already pending bit raises `irq_out` in the cycle after the write.
- R8: A write to offset 0x10 changes no state. Reads of any offset other than 0x10 and 0x14 return 0, and writes to them change no state. `bus_rdata` is 0 whenever no read is in progress.
- R9: An acknowledge read in the cycle right after another acknowledge read is rejected. It returns 0, clears nothing and drives `ack_gap_err` high for that cycle. A cycle with no acknowledge read in between (idle, or any other access) makes the next acknowledge read valid again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_master_lsb | input | 1 | Bit 0 of the master ID; 1 = debugger |
| bus_rdata | output | DATA_W (32) | Read data, valid in the access cycle |
| ack_gap_err | output | 1 | Back-to-back acknowledge read was rejected |
| event_pulse | input | NUM_EVENTS (32) | Single-cycle event pulses |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 32 events, a 32-bit data bus and a 12-bit offset. With these values the mask and pending paths are exercised on every bit position, including the top bit 31, and the checks cover the full data width rather than a narrowed copy. The 12-bit offset leaves room for random offsets that differ from the two live registers only in high bits. These reach the decode-miss path. Random bursts of acknowledge reads with randomly chosen master bits bring the rejected-read path into reach. The same bursts also cover the debugger path and the case where an event coincides with a clear.

// File: rtl/irq_status_pkg.sv
// Package: register offsets and decode target type shared by the
// interrupt status unit and its checker.
package irq_status_pkg;
    localparam int unsigned ACK_OFS = 32'h10;  // clear-on-read event register
    localparam int unsigned MSK_OFS = 32'h14;  // read/write mask register

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_ACK,
        TGT_MSK,
        TGT_MISS
    } reg_tgt_e;
endpackage

// File: rtl/irq_pending_bank.sv
// Sticky pending bits, one flop per event.
// Assumes: event pulses last one cycle; clr_mask only carries bits that
// were returned by an accepted, non-debugger acknowledge read.
// A set in the same cycle as a clear wins, so no event is lost.
module irq_pending_bank #(
    parameter int unsigned NUM_EVENTS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] event_pulse,
    input  logic [NUM_EVENTS-1:0] clr_mask,
    output logic [NUM_EVENTS-1:0] pend_q
);
    for (genvar g = 0; g < NUM_EVENTS; g++) begin : g_bit
        logic bit_q;
        // Purpose: hold one event until it is collected; set beats clear.
        always_ff @(posedge clk) begin
            if (!rst_n)              bit_q <= 1'b0;
            else if (event_pulse[g]) bit_q <= 1'b1;
            else if (clr_mask[g])    bit_q <= 1'b0;
        end
        assign pend_q[g] = bit_q;
    end
endmodule

// File: rtl/irq_mask_unit.sv
// Mask register and interrupt combine.
// Assumes: msk_we is a single-cycle strobe from the register decode.
// The interrupt line is a pure function of the stored state.
module irq_mask_unit #(
    parameter int unsigned NUM_EVENTS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  msk_we,
    input  logic [NUM_EVENTS-1:0] msk_wdata,
    input  logic [NUM_EVENTS-1:0] pend_q,
    output logic [NUM_EVENTS-1:0] msk_q,
    output logic                  irq_out
);
    // Purpose: store the per-bit interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n)      msk_q <= '0;
        else if (msk_we) msk_q <= msk_wdata;
    end

    // Purpose: raise the line while any unmasked bit is pending.
    always_comb irq_out = |(pend_q & msk_q);
endmodule

// File: rtl/irq_reg_decode.sv
// Register decode, read mux and acknowledge-read spacing guard.
// Assumes: read data is taken in the access cycle; bus_master_lsb = 1
// marks a debugger whose reads must not clear anything.
// An acknowledge read directly after another one is rejected.
module irq_reg_decode
    import irq_status_pkg::*;
#(
    parameter int unsigned NUM_EVENTS = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_master_lsb,
    input  logic [NUM_EVENTS-1:0] pend_q,
    input  logic [NUM_EVENTS-1:0] msk_q,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  ack_gap_err,
    output logic [NUM_EVENTS-1:0] clr_mask,
    output logic                  msk_we,
    output logic [NUM_EVENTS-1:0] msk_wdata
);
    localparam logic [ADDR_W-1:0] ACK_A = ADDR_W'(ACK_OFS);
    localparam logic [ADDR_W-1:0] MSK_A = ADDR_W'(MSK_OFS);

    reg_tgt_e tgt;
    logic     ack_rd;
    logic     ack_ok;
    logic     prev_ack_rd_q;

    // Purpose: map the offset to a register target.
    always_comb begin
        if (!bus_sel)               tgt = TGT_NONE;
        else if (bus_addr == ACK_A) tgt = TGT_ACK;
        else if (bus_addr == MSK_A) tgt = TGT_MSK;
        else                        tgt = TGT_MISS;
    end

    // Purpose: qualify acknowledge reads against the spacing rule.
    always_comb begin
        ack_rd      = (tgt == TGT_ACK) && !bus_write;
        ack_gap_err = ack_rd && prev_ack_rd_q;
        ack_ok      = ack_rd && !prev_ack_rd_q;
    end

    // Purpose: remember whether the last cycle held an acknowledge read.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_ack_rd_q <= 1'b0;
        else        prev_ack_rd_q <= ack_rd;
    end

    // Purpose: select read data; zero for misses, writes and rejects.
    always_comb begin
        bus_rdata = '0;
        if (!bus_write) begin
            unique case (tgt)
                TGT_ACK: if (ack_ok) bus_rdata = DATA_W'(pend_q);
                TGT_MSK: bus_rdata = DATA_W'(msk_q);
                default: bus_rdata = '0;
            endcase
        end
    end

    // Purpose: derive the clear set and the mask write strobe.
    always_comb begin
        clr_mask  = (ack_ok && !bus_master_lsb) ? pend_q : '0;
        msk_we    = (tgt == TGT_MSK) && bus_write;
        msk_wdata = bus_wdata[NUM_EVENTS-1:0];
    end
endmodule

// File: rtl/irq_status_unit.sv
// Top: clear-on-read interrupt status unit.
// Assumes: NUM_EVENTS <= DATA_W; a single synchronous active-low reset.
// It collects event pulses into sticky bits, masks them onto one
// interrupt line and clears them on acknowledge reads from non-debuggers.
module irq_status_unit #(
    parameter int unsigned NUM_EVENTS = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_master_lsb,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  ack_gap_err,
    input  logic [NUM_EVENTS-1:0] event_pulse,
    output logic                  irq_out
);
    logic [NUM_EVENTS-1:0] pend_q;
    logic [NUM_EVENTS-1:0] msk_q;
    logic [NUM_EVENTS-1:0] clr_mask;
    logic [NUM_EVENTS-1:0] msk_wdata;
    logic                  msk_we;

    irq_reg_decode #(
        .NUM_EVENTS(NUM_EVENTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) i_decode (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_master_lsb(bus_master_lsb),
        .pend_q(pend_q), .msk_q(msk_q),
        .bus_rdata(bus_rdata), .ack_gap_err(ack_gap_err),
        .clr_mask(clr_mask), .msk_we(msk_we), .msk_wdata(msk_wdata)
    );

    irq_pending_bank #(.NUM_EVENTS(NUM_EVENTS)) i_pending (
        .clk(clk), .rst_n(rst_n),
        .event_pulse(event_pulse), .clr_mask(clr_mask), .pend_q(pend_q)
    );

    irq_mask_unit #(.NUM_EVENTS(NUM_EVENTS)) i_mask (
        .clk(clk), .rst_n(rst_n),
        .msk_we(msk_we), .msk_wdata(msk_wdata), .pend_q(pend_q),
        .msk_q(msk_q), .irq_out(irq_out)
    );
endmodule

// File: rtl/irq_status_checker.sv
// Checker: temporal properties of the interrupt status unit, bound to
// every instance of the top. Observes ports plus the stored state.
module irq_status_checker
    import irq_status_pkg::*;
#(
    parameter int unsigned NUM_EVENTS = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_write,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic                  bus_master_lsb,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic                  ack_gap_err,
    input logic [NUM_EVENTS-1:0] event_pulse,
    input logic                  irq_out,
    input logic [NUM_EVENTS-1:0] pend_q,
    input logic [NUM_EVENTS-1:0] msk_q
);
    localparam logic [ADDR_W-1:0] ACK_A = ADDR_W'(ACK_OFS);
    localparam logic [ADDR_W-1:0] MSK_A = ADDR_W'(MSK_OFS);

    logic ack_rd_c;
    logic hit_ack;
    logic hit_msk;
    always_comb begin
        hit_ack  = bus_sel && (bus_addr == ACK_A);
        hit_msk  = bus_sel && (bus_addr == MSK_A);
        ack_rd_c = hit_ack && !bus_write;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && msk_q == '0 && !irq_out));

    assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (event_pulse != '0) |=> ((pend_q & $past(event_pulse)) == $past(event_pulse)));

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd_c && !ack_gap_err && !bus_master_lsb) |=>
        ((pend_q & $past(bus_rdata[NUM_EVENTS-1:0]) & ~$past(event_pulse)) == '0));

    assert_event_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd_c && !bus_master_lsb && ((event_pulse & pend_q) != '0)) |=>
        ((pend_q & $past(event_pulse)) == $past(event_pulse)));

    assert_debug_no_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd_c && bus_master_lsb) |=> (pend_q == ($past(pend_q) | $past(event_pulse))));

    assert_mask_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_msk && bus_write) |=> (msk_q == $past(bus_wdata[NUM_EVENTS-1:0])));

    assert_irq_on_unmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_msk && bus_write && ((bus_wdata[NUM_EVENTS-1:0] & pend_q) != '0)) |=> irq_out);

    assert_ack_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ack && bus_write) |=>
        (pend_q == ($past(pend_q) | $past(event_pulse)) && msk_q == $past(msk_q)));

    assert_miss_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !hit_ack && !hit_msk) |-> (bus_rdata == '0));

    assert_gap_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd_c && $past(ack_rd_c) && $past(rst_n)) |-> (ack_gap_err && bus_rdata == '0));
endmodule

bind irq_status_unit irq_status_checker #(
    .NUM_EVENTS(NUM_EVENTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_irq_status_checker (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_master_lsb(bus_master_lsb), .bus_rdata(bus_rdata),
    .ack_gap_err(ack_gap_err), .event_pulse(event_pulse),
    .irq_out(irq_out), .pend_q(pend_q), .msk_q(msk_q)
);

// File: tb/test_irq_status_unit.sv
// Bench: directed corner cases, then seeded random traffic, all checked
// against a reference model kept in bench variables.
module test_irq_status_unit;
    localparam int unsigned NE = 32;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 12;
    localparam logic [AW-1:0] A_ACK  = 12'h010;
    localparam logic [AW-1:0] A_MSK  = 12'h014;
    localparam logic [AW-1:0] A_MISS = 12'h018;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_master_lsb = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          ack_gap_err;
    logic [NE-1:0] event_pulse = '0;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state
    logic [NE-1:0] m_pend = '0;
    logic [NE-1:0] m_msk = '0;
    bit            m_prev_ack = 1'b0;

    always #5 clk = ~clk;

    irq_status_unit #(.NUM_EVENTS(NE), .DATA_W(DW), .ADDR_W(AW)) i_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_master_lsb(bus_master_lsb), .bus_rdata(bus_rdata),
        .ack_gap_err(ack_gap_err), .event_pulse(event_pulse), .irq_out(irq_out)
    );

    function automatic logic [DW-1:0] f_rdata(input bit sel, input bit wr,
            input logic [AW-1:0] a, input logic [NE-1:0] p,
            input logic [NE-1:0] m, input bit rej);
        if (!sel || wr) return '0;
        if (a == A_ACK) return rej ? '0 : p;
        if (a == A_MSK) return m;
        return '0;
    endfunction

    function automatic logic [NE-1:0] f_next_pend(input logic [NE-1:0] p,
            input logic [NE-1:0] ev, input bit clr);
        return (clr ? '0 : p) | ev;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: drive, check outputs mid-cycle, advance the model.
    task automatic step(input bit sel, input bit wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input bit dbg,
                        input logic [NE-1:0] ev, input string tag);
        bit ack_rd;
        bit rej;
        @(negedge clk);
        bus_sel = sel; bus_write = wr; bus_addr = a; bus_wdata = wd;
        bus_master_lsb = dbg; event_pulse = ev;
        #1;
        ack_rd = sel && !wr && (a == A_ACK);
        rej    = ack_rd && m_prev_ack;
        check(tag, "rdata", bus_rdata, f_rdata(sel, wr, a, m_pend, m_msk, rej));
        check(tag, "gap_err", DW'(ack_gap_err), DW'(rej));
        check(tag, "irq", DW'(irq_out), DW'(|(m_pend & m_msk)));
        @(posedge clk);
        m_pend = f_next_pend(m_pend, ev, ack_rd && !rej && !dbg);
        if (sel && wr && a == A_MSK) m_msk = wd;
        m_prev_ack = ack_rd;
    endtask

    task automatic idle(input logic [NE-1:0] ev, input string tag);
        step(1'b0, 1'b0, '0, '0, 1'b0, ev, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "irq in reset", DW'(irq_out), '0);
        rst_n = 1'b1;

        // R1: both registers and the line start cleared
        step(1'b1, 1'b0, A_MSK, '0, 1'b0, '0, "R1");
        step(1'b1, 1'b0, A_ACK, '0, 1'b0, '0, "R1");
        idle('0, "R1");

        // R2: masked events are still captured, incl. top bit
        idle(32'h8000_0020, "R2");
        idle('0, "R2");
        step(1'b1, 1'b0, A_ACK, '0, 1'b0, '0, "R2");
        idle('0, "R3");
        // R3: the previous read cleared what it returned
        step(1'b1, 1'b0, A_ACK, '0, 1'b0, '0, "R3");
        idle('0, "R3");

        // R4: event coinciding with a clearing read survives
        idle(32'h0000_0008, "R4");
        step(1'b1, 1'b0, A_ACK, '0, 1'b0, 32'h0000_0008, "R4");
        idle('0, "R4");
        step(1'b1, 1'b0, A_ACK, '0, 1'b0, '0, "R4");
        idle('0, "R4");

        // R5: debugger reads leave pending bits alone
        idle(32'h0000_0080, "R5");
        step(1'b1, 1'b0, A_ACK, '0, 1'b1, '0, "R5");
        idle('0, "R5");
        step(1'b1, 1'b0, A_ACK, '0, 1'b1, '0, "R5");
        idle('0, "R5");
        step(1'b1, 1'b0, A_ACK, '0, 1'b0, '0, "R5");
        idle('0, "R5");

        // R9: back-to-back read rejected, clears nothing, gap restores
        idle(32'h0000_0200, "R9");
        step(1'b1, 1'b0, A_ACK, '0, 1'b1, '0, "R9");
        step(1'b1, 1'b0, A_ACK, '0, 1'b0, '0, "R9");
        step(1'b1, 1'b0, A_MSK, '0, 1'b0, '0, "R9");
        step(1'b1, 1'b0, A_ACK, '0, 1'b0, '0, "R9");
        idle('0, "R9");

        // R8: write to acknowledge offset and unmapped traffic ignored
        idle(32'h0000_1000, "R8");
        step(1'b1, 1'b1, A_ACK, '1, 1'b0, '0, "R8");
        step(1'b1, 1'b1, A_MISS, '1, 1'b0, '0, "R8");
        step(1'b1, 1'b0, A_MISS, '0, 1'b0, '0, "R8");
        step(1'b1, 1'b0, A_MSK, '0, 1'b0, '0, "R8");
        step(1'b1, 1'b0, A_ACK, '0, 1'b0, '0, "R8");
        idle('0, "R8");

        // R6, R7: unmask a pending bit later, read mask back, then clear
        idle(32'h0010_0000, "R7");
        idle('0, "R7");
        step(1'b1, 1'b1, A_MSK, 32'h0010_0001, 1'b0, '0, "R6");
        step(1'b1, 1'b0, A_MSK, '0, 1'b0, '0, "R6");
        step(1'b1, 1'b0, A_ACK, '0, 1'b0, '0, "R7");
        idle('0, "R7");
        idle(32'h0000_0001, "R7");
        idle('0, "R7");

        // Random traffic covering all requirements R2..R9
        for (int n = 0; n < 3000; n++) begin
            bit            sel;
            bit            wr;
            bit            dbg;
            logic [AW-1:0] a;
            logic [DW-1:0] wd;
            logic [NE-1:0] ev;
            sel = ($urandom % 10) < 6;
            wr  = ($urandom % 3) == 0;
            dbg = ($urandom % 4) == 0;
            case ($urandom % 5)
                0, 1:    a = A_ACK;
                2:       a = A_MSK;
                3:       a = A_MISS;
                default: a = AW'($urandom) & ~AW'(3);
            endcase
            wd = $urandom;
            case ($urandom % 6)
                0:       ev = NE'(1) << ($urandom % NE);
                1:       ev = $urandom;
                default: ev = '0;
            endcase
            step(sel, wr, a, wd, dbg, ev, "RND");
        end
        idle('0, "RND");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule